// File: doc/BRIEF.md
# Video Memory Access Arbiter

This block decides who drives the shared text and colour memories of a character display: the scan counters or the CPU. While the raster is inside the region where characters are fetched, the memories follow the scan counters. At every other time they follow the CPU address bus. The block decodes CPU accesses to the two 4 KB video buffers. The text buffer sits at 0xE000 and the colour buffer at 0xD000, and the two are kept apart rather than interleaved.

When the CPU reaches for either buffer while the display owns the memories, the block drops a clock-enable output that freezes the CPU clock. The CPU then holds its address and strobes until blanking gives it the bus. Accesses to any other address are never held back, even in the middle of the visible area. Memory reads are asynchronous. A granted read is captured into a register, so the CPU sees the data from the next cycle on.

Top module: `vma_arbiter`

## Requirements
- R1: An address whose upper nibble (bits 15:12) is 0xE selects the text buffer, and upper nibble 0xD selects the colour buffer. No other address selects either buffer, and the offset inside a buffer is bits 11:0.
- R2: The display owns the memories when row < 480 and either column < 640 or column >= 792. The last 8 columns of each line are the one-character prefetch.
- R3: While the display owns the memories, `vmem_addr` = (row/16)*80 + column/8 for column < 640, and (row/16)*80 for the prefetch columns. Otherwise `vmem_addr` = CPU address bits 11:0.
- R4: `cpu_clk_en` is low in exactly the cycles where a read or write strobe targets a video buffer while the display owns the memories. It returns high in the first cycle the display releases them.
- R5: A strobe to an address outside 0xD000..0xEFFF never lowers `cpu_clk_en`, in any region.
- R6: `text_we` (`attr_we`) is high only when the write strobe is high, the address selects the text (colour) buffer, and the CPU owns the memories. No write enable is ever high while the display owns the memories.
- R7: After a clock edge where a read strobe to a buffer is granted, `cpu_rdata` holds that buffer's data at the granted address. It keeps its value across every other edge.
- R8: While `rst_n` is low, `cpu_rdata` is 0.
- R9: `vmem_wdata` always equals `cpu_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_col | input | 10 | Horizontal scan counter |
| scan_row | input | 10 | Vertical scan counter |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| text_rdata | input | 8 | Asynchronous read data of text memory |
| attr_rdata | input | 8 | Asynchronous read data of colour memory |
| vmem_addr | output | 12 | Shared address of both video memories |
| vmem_wdata | output | 8 | Write data to both memories |
| text_we | output | 1 | Text memory write enable |
| attr_we | output | 1 | Colour memory write enable |
| cpu_rdata | output | 8 | Captured read data returned to the CPU |
| cpu_clk_en | output | 1 | CPU clock enable; low freezes the CPU |

## Verification
Two functions can fall in the same cycle: the scan crossing a window edge, and a CPU strobe to a buffer that is held pending. The bench parks a write to the text buffer just before column 640, and another just before row 480. It then walks the counters across the boundary with the strobe held. The reference model expects the stall to end, and the write enable to pulse, in exactly the first column outside the window. Random vectors that mix buffer hits, misses and region positions are also compared every cycle. The same comparison covers the read data captured after each granted read.

// File: rtl/vma_pkg.sv
package vma_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_TEXT = 2'd1,
        SEL_ATTR = 2'd2
    } buf_sel_e;
endpackage

// File: rtl/vma_window.sv
module vma_window #(
    parameter int COL_W    = 10,
    parameter int ROW_W    = 10,
    parameter int H_ACTIVE = 640,
    parameter int V_ACTIVE = 480,
    parameter int H_TOTAL  = 800,
    parameter int PREFETCH = 8
) (
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    output logic             in_win,
    output logic             in_pre
);
    localparam logic [COL_W-1:0] PRE_START = COL_W'(H_TOTAL - PREFETCH);
    localparam logic [COL_W-1:0] COL_END   = COL_W'(H_ACTIVE);
    localparam logic [ROW_W-1:0] ROW_END   = ROW_W'(V_ACTIVE);

    always_comb begin
        in_pre = (col >= PRE_START);
        in_win = (row < ROW_END) && ((col < COL_END) || in_pre);
    end
endmodule

// File: rtl/vma_decode.sv
module vma_decode
    import vma_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              MEM_AW    = 12,
    parameter logic [15:0]     TEXT_BASE = 16'hE000,
    parameter logic [15:0]     ATTR_BASE = 16'hD000
) (
    input  logic [ADDR_W-1:0] addr,
    output buf_sel_e          sel
);
    localparam int TAG_W = ADDR_W - MEM_AW;
    localparam logic [ADDR_W-1:0] TB = ADDR_W'(TEXT_BASE);
    localparam logic [ADDR_W-1:0] AB = ADDR_W'(ATTR_BASE);
    localparam logic [TAG_W-1:0] TEXT_TAG = TB[ADDR_W-1:MEM_AW];
    localparam logic [TAG_W-1:0] ATTR_TAG = AB[ADDR_W-1:MEM_AW];

    logic [TAG_W-1:0] tag;

    always_comb begin
        tag = addr[ADDR_W-1:MEM_AW];
        if (tag == TEXT_TAG)      sel = SEL_TEXT;
        else if (tag == ATTR_TAG) sel = SEL_ATTR;
        else                      sel = SEL_NONE;
    end
endmodule

// File: rtl/vma_disp_addr.sv
module vma_disp_addr #(
    parameter int COL_W    = 10,
    parameter int ROW_W    = 10,
    parameter int MEM_AW   = 12,
    parameter int CHAR_W   = 8,
    parameter int CHAR_H   = 16,
    parameter int H_ACTIVE = 640
) (
    input  logic [COL_W-1:0]  col,
    input  logic [ROW_W-1:0]  row,
    input  logic              in_pre,
    output logic [MEM_AW-1:0] addr
);
    localparam int TEXT_COLS = H_ACTIVE / CHAR_W;
    localparam int CW_SH     = $clog2(CHAR_W);
    localparam int CH_SH     = $clog2(CHAR_H);

    logic [ROW_W-1:0] char_row;
    logic [COL_W-1:0] char_col;

    always_comb begin
        char_row = row >> CH_SH;
        char_col = in_pre ? '0 : (col >> CW_SH);
        addr     = MEM_AW'(char_row) * MEM_AW'(TEXT_COLS) + MEM_AW'(char_col);
    end
endmodule

// File: rtl/vma_arbiter.sv
module vma_arbiter
    import vma_pkg::*;
#(
    parameter int COL_W    = 10,
    parameter int ROW_W    = 10,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int MEM_AW   = 12,
    parameter int H_ACTIVE = 640,
    parameter int V_ACTIVE = 480,
    parameter int H_TOTAL  = 800,
    parameter int PREFETCH = 8,
    parameter int CHAR_W   = 8,
    parameter int CHAR_H   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  scan_col,
    input  logic [ROW_W-1:0]  scan_row,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] text_rdata,
    input  logic [DATA_W-1:0] attr_rdata,
    output logic [MEM_AW-1:0] vmem_addr,
    output logic [DATA_W-1:0] vmem_wdata,
    output logic              text_we,
    output logic              attr_we,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_clk_en
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic              in_win, in_pre;
    buf_sel_e          sel;
    logic [MEM_AW-1:0] disp_addr;
    logic              hit, busy, grant, stall;

    vma_window #(
        .COL_W(COL_W), .ROW_W(ROW_W), .H_ACTIVE(H_ACTIVE),
        .V_ACTIVE(V_ACTIVE), .H_TOTAL(H_TOTAL), .PREFETCH(PREFETCH)
    ) u_window (
        .col(scan_col), .row(scan_row), .in_win(in_win), .in_pre(in_pre)
    );

    vma_decode #(
        .ADDR_W(ADDR_W), .MEM_AW(MEM_AW)
    ) u_decode (
        .addr(cpu_addr), .sel(sel)
    );

    vma_disp_addr #(
        .COL_W(COL_W), .ROW_W(ROW_W), .MEM_AW(MEM_AW),
        .CHAR_W(CHAR_W), .CHAR_H(CHAR_H), .H_ACTIVE(H_ACTIVE)
    ) u_disp (
        .col(scan_col), .row(scan_row), .in_pre(in_pre), .addr(disp_addr)
    );

    always_comb begin
        hit        = (sel != SEL_NONE);
        busy       = cpu_rd || cpu_wr;
        grant      = hit && !in_win;
        stall      = busy && hit && in_win;
        cpu_clk_en = !stall;
        vmem_addr  = in_win ? disp_addr : cpu_addr[MEM_AW-1:0];
        vmem_wdata = cpu_wdata;
        text_we    = cpu_wr && grant && (sel == SEL_TEXT);
        attr_we    = cpu_wr && grant && (sel == SEL_ATTR);

        st_d = st_q;
        if (cpu_rd && grant) begin
            st_d.rdata = (sel == SEL_TEXT) ? text_rdata : attr_rdata;
        end
        cpu_rdata = st_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    no_win_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> !(text_we || attr_we));

    // R6
    single_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({text_we, attr_we}));

    // R4
    win_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hit && in_win) |-> !cpu_clk_en);

    // R5
    miss_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> cpu_clk_en);

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && hit && !in_win) |=> $stable(cpu_rdata));

    // R3
    cpu_addr_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_win) |-> (vmem_addr == cpu_addr[MEM_AW-1:0]));
endmodule

// File: tb/vma_arbiter_tb.sv
module vma_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  scan_col = '0;
    logic [9:0]  scan_row = '0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  text_rdata, attr_rdata;
    logic [11:0] vmem_addr;
    logic [7:0]  vmem_wdata, cpu_rdata;
    logic        text_we, attr_we, cpu_clk_en;

    logic [7:0] text_mem [4096];
    logic [7:0] attr_mem [4096];

    int vectors = 0;
    int errors  = 0;
    logic [7:0] exp_rdata = 8'h00;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vma_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .scan_col(scan_col), .scan_row(scan_row),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .text_rdata(text_rdata), .attr_rdata(attr_rdata),
        .vmem_addr(vmem_addr), .vmem_wdata(vmem_wdata), .text_we(text_we),
        .attr_we(attr_we), .cpu_rdata(cpu_rdata), .cpu_clk_en(cpu_clk_en)
    );

    assign text_rdata = text_mem[vmem_addr];
    assign attr_rdata = attr_mem[vmem_addr];

    always @(posedge clk) begin
        if (text_we) text_mem[vmem_addr] <= vmem_wdata;
        if (attr_we) attr_mem[vmem_addr] <= vmem_wdata;
    end

    function automatic int region(input logic [15:0] a);
        if (a[15:12] == 4'hE) return 1;   // R1 text
        if (a[15:12] == 4'hD) return 2;   // R1 colour
        return 0;
    endfunction

    function automatic bit owned(input int c, input int r);
        return (r < 480) && ((c < 640) || (c >= 792));   // R2
    endfunction

    function automatic int disp_addr(input int c, input int r);
        if (c >= 792) return (r / 16) * 80;                // R3 prefetch
        return (r / 16) * 80 + (c / 8);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (col=%0d row=%0d addr=%h)",
                     tag, act, exp, scan_col, scan_row, cpu_addr);
        end
    endtask

    task automatic apply(input int c, input int r, input logic [15:0] a,
                         input bit rd, input bit wr, input logic [7:0] wd);
        int  reg_id;
        bit  win, exp_stall, exp_twe, exp_awe;
        int  exp_addr;
        logic [7:0] nxt;
        @(negedge clk);
        scan_col = 10'(c); scan_row = 10'(r);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
        #1;
        reg_id    = region(a);
        win       = owned(c, r);
        exp_stall = (rd || wr) && (reg_id != 0) && win;
        exp_twe   = wr && (reg_id == 1) && !win;
        exp_awe   = wr && (reg_id == 2) && !win;
        exp_addr  = win ? disp_addr(c, r) : int'(a[11:0]);
        vectors++;
        check("R4 R5 cpu_clk_en", int'(cpu_clk_en), int'(!exp_stall));
        check("R1 R6 text_we", int'(text_we), int'(exp_twe));
        check("R1 R6 attr_we", int'(attr_we), int'(exp_awe));
        check("R2 R3 vmem_addr", int'(vmem_addr), exp_addr);
        check("R9 vmem_wdata", int'(vmem_wdata), int'(wd));
        check("R7 cpu_rdata", int'(cpu_rdata), int'(exp_rdata));
        nxt = exp_rdata;
        if (rd && reg_id != 0 && !win)
            nxt = (reg_id == 1) ? text_mem[a[11:0]] : attr_mem[a[11:0]];
        @(posedge clk);
        exp_rdata = nxt;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            text_mem[i] = 8'(i * 7 + 3);
            attr_mem[i] = 8'(i * 13 + 5);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        check("R8 reset cpu_rdata", int'(cpu_rdata), 0);
        rst_n = 1'b1;

        // window edges, idle CPU
        apply(0, 0, 16'h0000, 0, 0, 8'h00);
        apply(639, 479, 16'h1234, 0, 0, 8'h00);
        apply(640, 479, 16'h1234, 0, 0, 8'h00);
        apply(791, 100, 16'hE055, 0, 0, 8'h00);
        apply(792, 100, 16'hE055, 0, 0, 8'h00);
        apply(799, 479, 16'hD055, 0, 0, 8'h00);
        apply(100, 480, 16'hD0AA, 0, 0, 8'h00);

        // R5 non-video accesses inside the window
        apply(10, 10, 16'hC000, 1, 0, 8'h11);
        apply(20, 10, 16'hF000, 0, 1, 8'h22);
        apply(30, 10, 16'h0FFF, 1, 0, 8'h33);

        // R4 R6 text write held across column 640, completes at 640
        for (int c = 634; c <= 642; c++) apply(c, 10, 16'hE123, 0, 1, 8'hA5);
        // R7 read it back in blanking
        apply(700, 10, 16'hE123, 1, 0, 8'h00);
        apply(701, 10, 16'h0000, 0, 0, 8'h00);
        apply(702, 10, 16'h0000, 0, 0, 8'h00);

        // R4 colour write held across row 480
        for (int r = 478; r <= 481; r++) apply(300, r, 16'hDFFE, 0, 1, 8'h5A);
        apply(300, 490, 16'hDFFE, 1, 0, 8'h00);
        apply(301, 490, 16'hE000, 1, 0, 8'h00);
        // R2 prefetch columns stall a held read, release at column 640 of next region
        apply(795, 20, 16'hD001, 1, 0, 8'h00);
        apply(640, 20, 16'hD001, 1, 0, 8'h00);

        // mixed random vectors
        for (int k = 0; k < 3000; k++) begin
            int c, r, pick;
            logic [15:0] a;
            bit rd, wr;
            c = $urandom_range(0, 799);
            r = $urandom_range(0, 524);
            pick = $urandom_range(0, 3);
            a = 16'($urandom);
            if (pick == 0) a[15:12] = 4'hE;
            else if (pick == 1) a[15:12] = 4'hD;
            rd = ($urandom_range(0, 1) == 1);
            wr = !rd && ($urandom_range(0, 2) != 0);
            apply(c, r, a, rd, wr, 8'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule